// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block is the input side of a serial audio port, acting only as a slave. An external bit clock and frame clock, both synchronous to the system clock, time up to four serial data lanes. The block never drives those clocks. It oversamples them with the system clock, finds the active bit-clock edge, and deserializes each lane into words. In the stereo formats, every lane yields a left word and a right word. In the two eight-slot time-division formats, lane 0 alone carries eight 32-bit slots per frame.

A three-bit format code selects the format. Two polarity inputs can invert the bit clock and the frame clock. Each completed word leaves the block as a 24-bit left-aligned value per lane, together with a channel or slot number and a one-cycle valid strobe. A word is presented when the first bit of the following word arrives. The word that is in progress when the block first locks after reset is discarded.

Top module: `serial_audio_rx`

## Requirements
- R1: `cfg_fmt` selects the format: 0 = I2S, 1 = left-justified, 2/3/4/5 = right-justified with 24/20/18/16-bit words, 6 = TDM with 50% frame clock, 7 = TDM with one-bit frame pulse; the all-zero code (the tie-off default) is I2S.
- R2: In I2S, a left word starts with the bit one bit clock after the frame clock falls and a right word one bit clock after it rises (left while frame clock is low).
- R3: In left-justified, the MSB is the bit sampled at the frame clock edge; frame clock high marks the left word.
- R4: In right-justified modes with word width W, each half frame is 32 bit clocks, the MSB sits 32-W bits after the frame clock edge, and the output word is the W bits left-aligned with the 24-W low bits zero.
- R5: In I2S, left-justified and TDM, a word of N bits is accepted for any N: for N<24 the low 24-N output bits are zero; for N>24 only the first 24 bits are kept, with no error.
- R6: Code 6: a frame starts one bit clock after the frame clock falls; eight 32-bit slots on lane 0, the first 24 bits of each slot form the word, `out_chan` is the slot number 0..7, and lanes 1 to 3 of `out_data` read zero.
- R7: Code 7: a frame starts one bit clock after the rise of a frame pulse one bit clock wide; slots as in R6.
- R8: With `cfg_bclk_inv`=0 data is sampled on the rising bit-clock edge, with 1 on the falling edge; `cfg_fclk_inv`=1 inverts the frame clock before all framing rules.
- R9: `out_valid` is a single-cycle pulse; in stereo formats `out_chan` is 0 for left and 1 for right; lane L is at `out_data[24L+23:24L]`, MSB first; `out_data` changes only with `out_valid`.
- R10: A word is presented three system-clock cycles after the active bit-clock edge that samples the first bit of the following word; the word in progress when the block first finds a word or frame boundary after reset is not presented.
- R11: During reset `out_valid`, `out_chan` and `out_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fmt | input | 3 | Format code (R1) |
| cfg_bclk_inv | input | 1 | Sample on falling bit-clock edge when 1 |
| cfg_fclk_inv | input | 1 | Invert frame clock when 1 |
| bclk | input | 1 | External bit clock |
| fclk | input | 1 | External frame clock or frame pulse |
| sdata | input | LINES | Serial data lanes |
| out_valid | output | 1 | Word strobe |
| out_chan | output | 3 | Channel (stereo) or slot (TDM) |
| out_data | output | LINES*24 | Received words, one 24-bit field per lane |

## Verification
Every result is due at a fixed point: three system-clock cycles after the bench drives the active bit-clock edge that opens the next word. This delay comes from two synchronizer stages plus the output register. While it builds the serial stream, the bench stores the cycle at which each word is due. On every falling system-clock edge it requires `out_valid` exactly at that cycle, with the expected channel and data, and requires no strobe at any other cycle. After each stream, it confirms that no expected word is still outstanding. This covers the discarded first word, truncation, zero padding and the ignored lanes in TDM.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    localparam int WORD_W = 24;
    localparam int SLOT_W = 32;
    localparam int SLOTS  = 8;
    localparam int POS_W  = $clog2(SLOT_W);
    localparam int CHAN_W = $clog2(SLOTS);
    localparam int CNT_W  = POS_W + CHAN_W;

    typedef enum logic [2:0] {
        FMT_I2S       = 3'd0,
        FMT_LEFT      = 3'd1,
        FMT_RJ24      = 3'd2,
        FMT_RJ20      = 3'd3,
        FMT_RJ18      = 3'd4,
        FMT_RJ16      = 3'd5,
        FMT_TDM_CLK   = 3'd6,
        FMT_TDM_PULSE = 3'd7
    } fmt_e;

    // word width carried by a right-justified half frame; full width otherwise
    function automatic int rj_width(fmt_e f);
        case (f)
            FMT_RJ20: return 20;
            FMT_RJ18: return 18;
            FMT_RJ16: return 16;
            default:  return 24;
        endcase
    endfunction

    function automatic int rj_offset(fmt_e f);
        if (f inside {FMT_RJ24, FMT_RJ20, FMT_RJ18, FMT_RJ16})
            return SLOT_W - rj_width(f);
        return 0;
    endfunction

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sarx_edge.sv
module sarx_edge #(
    parameter int LINES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_s,
    input  logic             fclk_s,
    input  logic [LINES-1:0] data_s,
    input  logic             bclk_inv,
    input  logic             fclk_inv,
    output logic             strobe,
    output logic             fbit,
    output logic [LINES-1:0] dbits
);
    logic norm;
    logic prev_d, prev_q;

    always_comb begin
        norm   = bclk_s ^ bclk_inv;
        prev_d = norm;
        strobe = norm & ~prev_q;
        fbit   = fclk_s ^ fclk_inv;
        dbits  = data_s;
    end

    // reset high so an idle clock never looks like an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/sarx_deser.sv
module sarx_deser
    import sarx_pkg::*;
#(
    parameter int LINES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  fmt_e                      fmt,
    input  logic                      strobe,
    input  logic                      fbit,
    input  logic [LINES-1:0]          dbits,
    output logic                      vld,
    output logic [CHAN_W-1:0]         chan,
    output logic [LINES*WORD_W-1:0]   data
);
    localparam int ACC_W = LINES * WORD_W;

    typedef struct packed {
        logic [1:0]        seen;
        logic              f1;
        logic              f2;
        logic              ch;
        logic              armed;
        logic [CNT_W-1:0]  cnt;
        logic [CHAN_W-1:0] wchan;
        logic [ACC_W-1:0]  acc;
        logic              vld;
        logic [CHAN_W-1:0] ochan;
        logic [ACC_W-1:0]  odata;
    } st_t;

    st_t st_d, st_q;

    logic             tdm, ready, ch_now, start, bnd;
    logic [CNT_W-1:0] idx;
    int               pos;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;

        tdm    = (fmt == FMT_TDM_CLK) || (fmt == FMT_TDM_PULSE);
        ready  = (st_q.seen == 2'd2);
        // 1 = left; I2S lags the frame clock by one bit
        ch_now = (fmt == FMT_I2S) ? ~st_q.f1 : fbit;
        start  = tdm & ready & ((fmt == FMT_TDM_CLK) ? (st_q.f2 & ~st_q.f1)
                                                     : (~st_q.f2 & st_q.f1));
        if (tdm)
            bnd = start | (ready & st_q.armed & (st_q.cnt != '1) &
                           (st_q.cnt[POS_W-1:0] == '1));
        else
            bnd = ready & (ch_now != st_q.ch);

        if ((bnd && !tdm) || start) idx = '0;
        else if (st_q.cnt == '1)    idx = st_q.cnt;
        else                        idx = st_q.cnt + 1'b1;

        pos = tdm ? int'(idx[POS_W-1:0]) : int'(idx) - rj_offset(fmt);

        if (strobe) begin
            if (bnd) begin
                if (st_q.armed) begin
                    st_d.vld   = 1'b1;
                    st_d.ochan = st_q.wchan;
                    st_d.odata = st_q.acc;
                end
                st_d.acc   = '0;
                st_d.armed = tdm ? (st_q.armed | start) : 1'b1;
                st_d.wchan = tdm ? idx[CNT_W-1:POS_W]
                                 : (ch_now ? '0 : CHAN_W'(1));
            end
            if (pos >= 0 && pos < WORD_W) begin
                for (int l = 0; l < LINES; l++) begin
                    if (!tdm || l == 0)
                        st_d.acc[l*WORD_W + WORD_W - 1 - pos] = dbits[l];
                end
            end
            st_d.cnt = idx;
            st_d.ch  = ch_now;
            st_d.f2  = st_q.f1;
            st_d.f1  = fbit;
            if (st_q.seen != 2'd2) st_d.seen = st_q.seen + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld  = st_q.vld;
    assign chan = st_q.ochan;
    assign data = st_q.odata;
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int LINES       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              cfg_fmt,
    input  logic                    cfg_bclk_inv,
    input  logic                    cfg_fclk_inv,
    input  logic                    bclk,
    input  logic                    fclk,
    input  logic [LINES-1:0]        sdata,
    output logic                    out_valid,
    output logic [CHAN_W-1:0]       out_chan,
    output logic [LINES*WORD_W-1:0] out_data
);
    localparam int SW = LINES + 2;

    logic [SW-1:0]    raw_s;
    logic             strobe, fbit;
    logic [LINES-1:0] dbits;

    sarx_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sdata, fclk, bclk}),
        .dout (raw_s)
    );

    sarx_edge #(.LINES(LINES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_s  (raw_s[0]),
        .fclk_s  (raw_s[1]),
        .data_s  (raw_s[SW-1:2]),
        .bclk_inv(cfg_bclk_inv),
        .fclk_inv(cfg_fclk_inv),
        .strobe  (strobe),
        .fbit    (fbit),
        .dbits   (dbits)
    );

    sarx_deser #(.LINES(LINES)) u_deser (
        .clk   (clk),
        .rst_n (rst_n),
        .fmt   (fmt_e'(cfg_fmt)),
        .strobe(strobe),
        .fbit  (fbit),
        .dbits (dbits),
        .vld   (out_valid),
        .chan  (out_chan),
        .data  (out_data)
    );
endmodule

// File: rtl/sarx_chk.sv
module sarx_chk
    import sarx_pkg::*;
#(
    parameter int LINES = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [2:0]              cfg_fmt,
    input logic                    out_valid,
    input logic [CHAN_W-1:0]       out_chan,
    input logic [LINES*WORD_W-1:0] out_data
);
    logic is_tdm;
    logic pad_nz;

    always_comb begin
        is_tdm = (cfg_fmt == 3'd6) || (cfg_fmt == 3'd7);
        pad_nz = 1'b0;
        for (int l = 0; l < LINES; l++) begin
            for (int b = 0; b < WORD_W - rj_width(fmt_e'(cfg_fmt)); b++)
                pad_nz = pad_nz | out_data[l*WORD_W + b];
        end
    end

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_data) |-> out_valid);

    // R9
    stereo_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !is_tdm) |-> (out_chan <= CHAN_W'(1)));

    // R6
    tdm_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && is_tdm) |-> (out_data[LINES*WORD_W-1:WORD_W] == '0));

    // R4
    rj_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !pad_nz);
endmodule

bind serial_audio_rx sarx_chk #(.LINES(LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_fmt  (cfg_fmt),
    .out_valid(out_valid),
    .out_chan (out_chan),
    .out_data (out_data)
);

// File: tb/serial_audio_rx_tb.sv
`timescale 1ns/1ps
module serial_audio_rx_tb;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_fmt = 3'd0;
    logic        cfg_bclk_inv = 1'b0, cfg_fclk_inv = 1'b0;
    logic        bclk = 1'b0, fclk = 1'b0;
    logic [3:0]  sdata = 4'd0;
    logic        out_valid;
    logic [2:0]  out_chan;
    logic [95:0] out_data;

    always #2 clk = ~clk;

    serial_audio_rx u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt),
        .cfg_bclk_inv(cfg_bclk_inv), .cfg_fclk_inv(cfg_fclk_inv),
        .bclk(bclk), .fclk(fclk), .sdata(sdata),
        .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data)
    );

    typedef struct {
        logic        f;
        logic [3:0]  d;
        bit          is_start;
        int          chan;
        bit          has_exp;
        logic [2:0]  ec;
        logic [95:0] ed;
    } sbit_t;

    typedef struct {
        int          due;
        logic [2:0]  c;
        logic [95:0] d;
    } exp_t;

    sbit_t stream[$];
    exp_t  expq[$];
    bit          pend_v;
    logic [2:0]  pend_c;
    logic [95:0] pend_d;
    int    cyc = 0;
    int    total = 0, bad = 0;
    bit    running = 0;
    bit    done = 0;
    string cur_req = "R1";

    always @(posedge clk) cyc <= cyc + 1;

    // per-clock comparison against the expected-word queue (R9, R10)
    always @(negedge clk) begin
        if (running) begin
            if (expq.size() > 0 && cyc == expq[0].due) begin
                total++;
                if (!out_valid || out_chan !== expq[0].c || out_data !== expq[0].d) begin
                    bad++;
                    $display("FAIL %s R9 R10: valid=%0b chan=%0d data=%h expected valid=1 chan=%0d data=%h",
                             cur_req, out_valid, out_chan, out_data, expq[0].c, expq[0].d);
                end
                void'(expq.pop_front());
            end else if (out_valid) begin
                total++;
                bad++;
                $display("FAIL %s R10: unexpected valid chan=%0d data=%h expected no strobe",
                         cur_req, out_chan, out_data);
            end
        end
    end

    task automatic add_word(int chan, int h, int off, int nb, logic [127:0] vals,
                            bit tdm, bit emit);
        logic [95:0] ed;
        for (int i = 0; i < h; i++) begin
            sbit_t b;
            b.f = 1'b0;
            b.chan = chan;
            b.is_start = (i == 0);
            b.has_exp = (i == 0) && pend_v;
            b.ec = pend_c;
            b.ed = pend_d;
            for (int l = 0; l < 4; l++) begin
                if (tdm && l > 0)                    b.d[l] = 1'($urandom);
                else if (i >= off && i - off < nb)   b.d[l] = vals[32*l + nb - 1 - (i - off)];
                else                                 b.d[l] = 1'b0;
            end
            stream.push_back(b);
        end
        ed = '0;
        for (int l = 0; l < 4; l++) begin
            logic [63:0] lane, e;
            lane = 64'(vals[32*l +: 32]) & ((64'd1 << nb) - 64'd1);
            if (nb >= 24) e = lane >> (nb - 24);
            else          e = lane << (24 - nb);
            if (!(tdm && l > 0)) ed[24*l +: 24] = e[23:0];
        end
        pend_v = emit;
        pend_c = 3'(chan);
        pend_d = ed;
    endtask

    task automatic set_frame_levels(int fmt);
        for (int k = 0; k < stream.size(); k++) begin
            int nx;
            nx = (k + 1 < stream.size()) ? k + 1 : k;
            case (fmt)
                0:       stream[k].f = !(stream[nx].chan == 0);
                6:       stream[k].f = !(stream[nx].chan < 4);
                7:       stream[k].f = (k + 1 < stream.size()) && stream[k+1].is_start
                                       && stream[k+1].chan == 0;
                default: stream[k].f = (stream[k].chan == 0);
            endcase
        end
    endtask

    task automatic play(bit binv, bit finv);
        foreach (stream[k]) begin
            @(posedge clk); #1;
            bclk  = binv;
            fclk  = stream[k].f ^ finv;
            sdata = stream[k].d;
            repeat (3) @(posedge clk);
            #1;
            bclk = ~binv;
            if (stream[k].has_exp) begin
                exp_t e;
                e.due = cyc + LAT;
                e.c = stream[k].ec;
                e.d = stream[k].ed;
                expq.push_back(e);
            end
            repeat (3) @(posedge clk);
        end
        repeat (12) @(posedge clk);
        #1;
        total++;
        if (expq.size() != 0) begin
            bad++;
            $display("FAIL %s R10: %0d words outstanding expected 0", cur_req, expq.size());
        end
    endtask

    task automatic start_test(int fmt, bit binv, bit finv, string req);
        running = 0;
        rst_n = 1'b0;
        cfg_fmt = 3'(fmt);
        cfg_bclk_inv = binv;
        cfg_fclk_inv = finv;
        bclk = binv;
        fclk = finv;
        sdata = '0;
        stream.delete();
        expq.delete();
        pend_v = 0;
        cur_req = req;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        running = 1;
    endtask

    task automatic run_stereo(int fmt, int h, int off, int nb, bit binv, bit finv, string req);
        start_test(fmt, binv, finv, req);
        add_word(1, 3, 0, 24, '0, 0, 0);
        for (int fr = 0; fr < 2; fr++) begin
            add_word(0, h, off, nb, {$urandom, $urandom, $urandom, $urandom}, 0, 1);
            add_word(1, h, off, nb, {$urandom, $urandom, $urandom, $urandom}, 0, 1);
        end
        add_word(0, 3, 0, 24, '0, 0, 0);
        set_frame_levels(fmt);
        play(binv, finv);
    endtask

    task automatic run_tdm(int fmt, string req);
        start_test(fmt, 0, 0, req);
        add_word(7, 3, 0, 24, '0, 1, 0);
        for (int fr = 0; fr < 2; fr++)
            for (int s = 0; s < 8; s++)
                add_word(s, 32, 0, 24, {$urandom, $urandom, $urandom, $urandom}, 1, 1);
        add_word(0, 3, 0, 24, '0, 1, 0);
        set_frame_levels(fmt);
        play(0, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R11: outputs during reset
        repeat (2) @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || out_chan !== 3'd0 || out_data !== '0) begin
            bad++;
            $display("FAIL R11: valid=%0b chan=%0d data=%h expected 0 0 0",
                     out_valid, out_chan, out_data);
        end
        run_stereo(0, 32, 0, 24, 0, 0, "R1 R2 i2s");
        run_stereo(1, 20, 0, 16, 0, 0, "R3 R5 lj short");
        run_stereo(0, 32, 0, 28, 0, 0, "R5 i2s long");
        run_stereo(2, 32, 8, 24, 0, 0, "R4 rj24");
        run_stereo(3, 32, 12, 20, 0, 0, "R4 rj20");
        run_stereo(4, 32, 14, 18, 0, 0, "R4 rj18");
        run_stereo(5, 32, 16, 16, 0, 0, "R4 rj16");
        run_stereo(1, 32, 0, 24, 1, 1, "R8 inverted");
        run_stereo(0, 32, 0, 24, 1, 0, "R8 bclk only");
        run_tdm(6, "R6 tdm clock");
        run_tdm(7, "R7 tdm pulse");
        running = 0;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule